// File: doc/BRIEF.md
# Edge-Triggered Vertical Border Generator

This block decides, once per raster line, whether the top and bottom border covers the line and whether a text row may be drawn on it. The border is not found by comparing the raster against a range. It is a latched state. The state turns on only when the raster equals the border-on line exactly, and turns off only when the raster equals the border-off line exactly. A program that moves the border-on compare value past the current raster, so that the raster never meets it, keeps the border away for that whole frame.

Text rows are limited by a row-count register inside the block, which is loaded through a write strobe. After reset the register holds 25. A line carries text only when its row index is below that count, where the row index is the line's offset from the text start line divided by the row height. Every compare is made on the start-of-line strobe. Both outputs are registered, so they change only in the cycle after a strobe and hold steady for the rest of the line. The border state machine has two states. In BORDER_SHOWN it takes the transition CLEAR_ON_END when the raster equals the border-off line. In BORDER_HIDDEN it takes the transition SET_ON_START when the raster equals the border-on line. In every other case it takes HOLD and keeps its state.

Top module: `vborder_gen`

## Requirements
- R1: At a line strobe in state BORDER_HIDDEN, if the raster equals `border_on_line`, then `border_active` is 1 from the next cycle onward.
- R2: In state BORDER_HIDDEN, a strobe whose raster differs from `border_on_line` leaves `border_active` at 0. A border-on value that the raster has already passed therefore keeps the border off for the rest of the frame.
- R3: At a line strobe in state BORDER_SHOWN, if the raster equals `border_off_line`, then `border_active` is 0 from the next cycle onward. No other raster value clears it.
- R4: After reset, `border_active` is 1, `text_row_enable` is 0, and the row-count register holds 25.
- R5: At a strobe, `text_row_enable` becomes 1 exactly when three things hold: the border is off for that line, raster >= `text_first_line`, and (raster - `text_first_line`) / `row_height` < row count. This is the same as raster - `text_first_line` < row count * `row_height`.
- R6: Whenever `border_active` is 1, `text_row_enable` is 0.
- R7: A row count of 0 or a `row_height` of 0 keeps `text_row_enable` at 0 on every line.
- R8: Both outputs change only in the cycle that follows a line strobe. Input and register changes made between strobes have no effect until the next strobe.
- R9: A cycle with `rows_we` = 1 loads `rows_wdata` into the row-count register. The new count is used from the next line strobe onward.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| line_strobe | input | 1 | One-cycle pulse at the start of each raster line |
| raster_line | input | LINE_W | Current raster line number |
| border_on_line | input | LINE_W | Line whose exact match turns the border on |
| border_off_line | input | LINE_W | Line whose exact match turns the border off |
| text_first_line | input | LINE_W | First raster line of text row 0 |
| row_height | input | ROW_H_W | Lines per text row |
| rows_we | input | 1 | Write strobe for the row-count register |
| rows_wdata | input | ROW_CNT_W | New row count |
| border_active | output | 1 | Vertical border covers the current line |
| text_row_enable | output | 1 | Text may be drawn on the current line |

## Verification
The bench builds the block with a 6-bit raster, a 5-bit row count and a 3-bit row height. At these sizes every line of a 64-line frame can be swept for each combination of row count {25, 0, 3, 31} and row height {0, 1, 3, 7}. This sweep covers the zero cases and also the case where a 25-row window ends before the frame does. The narrow raster also makes it cheap to move the border-on value behind the raster partway through a frame, which lets the bench watch one whole frame pass without a border.

// File: rtl/vb_pkg.sv
package vb_pkg;
    typedef enum logic {
        BORDER_HIDDEN = 1'b0,
        BORDER_SHOWN  = 1'b1
    } vb_state_e;
endpackage

// File: rtl/vb_rowcount_reg.sv
module vb_rowcount_reg #(
    parameter int ROW_CNT_W  = 8,
    parameter int RESET_ROWS = 25
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 we,
    input  logic [ROW_CNT_W-1:0] wdata,
    output logic [ROW_CNT_W-1:0] rows
);
    localparam logic [ROW_CNT_W-1:0] RESET_VAL = ROW_CNT_W'(RESET_ROWS);

    always_ff @(posedge clk) begin
        if (!rst_n)
            rows <= RESET_VAL;
        else if (we)
            rows <= wdata;
    end

    // R9: a write is visible in the register on the following cycle
    p_write_load_r9: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> rows == $past(wdata));
endmodule

// File: rtl/vb_border_fsm.sv
module vb_border_fsm
    import vb_pkg::*;
#(
    parameter int LINE_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              line_strobe,
    input  logic [LINE_W-1:0] raster_line,
    input  logic [LINE_W-1:0] on_line,
    input  logic [LINE_W-1:0] off_line,
    output vb_state_e         state_next,
    output logic              border_active
);
    vb_state_e state_q;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= BORDER_SHOWN;
        else
            state_q <= state_next;
    end

    // transitions: SET_ON_START, CLEAR_ON_END, HOLD
    always_comb begin
        state_next = state_q;
        if (line_strobe) begin
            unique case (state_q)
                BORDER_SHOWN:  if (raster_line == off_line) state_next = BORDER_HIDDEN;
                BORDER_HIDDEN: if (raster_line == on_line)  state_next = BORDER_SHOWN;
                default:       state_next = BORDER_SHOWN;
            endcase
        end
    end

    // outputs
    always_comb begin
        unique case (state_q)
            BORDER_SHOWN:  border_active = 1'b1;
            BORDER_HIDDEN: border_active = 1'b0;
            default:       border_active = 1'b1;
        endcase
    end

    // R1: exact match turns the border on
    p_set_on_match_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (line_strobe && !border_active && raster_line == on_line) |=> border_active);
    // R2: without an exact match the border stays off
    p_stay_off_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!border_active && !(line_strobe && raster_line == on_line)) |=> !border_active);
    // R3: exact match turns the border off, nothing else does
    p_clear_on_match_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (line_strobe && border_active && raster_line == off_line) |=> !border_active);
    p_stay_on_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (border_active && !(line_strobe && raster_line == off_line)) |=> border_active);
endmodule

// File: rtl/vb_text_window.sv
module vb_text_window
    import vb_pkg::*;
#(
    parameter int LINE_W    = 10,
    parameter int ROW_CNT_W = 8,
    parameter int ROW_H_W   = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 line_strobe,
    input  logic [LINE_W-1:0]    raster_line,
    input  logic [LINE_W-1:0]    first_line,
    input  logic [ROW_H_W-1:0]   row_height,
    input  logic [ROW_CNT_W-1:0] rows,
    input  vb_state_e            border_next,
    output logic                 text_en
);
    localparam int PROD_W = ROW_CNT_W + ROW_H_W;
    localparam int CMP_W  = ((LINE_W > PROD_W) ? LINE_W : PROD_W) + 1;

    logic [CMP_W-1:0] offset;
    logic [CMP_W-1:0] span;
    logic             after_start;
    logic             in_window;

    // row index < rows  <=>  offset < rows * height (no divider needed)
    always_comb begin
        after_start = raster_line >= first_line;
        offset      = CMP_W'(raster_line) - CMP_W'(first_line);
        span        = CMP_W'(rows) * CMP_W'(row_height);
        in_window   = after_start && (offset < span) && (border_next == BORDER_HIDDEN);
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            text_en <= 1'b0;
        else if (line_strobe)
            text_en <= in_window;
    end

    // R7: zero rows or zero height never yields text
    p_zero_rows_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (line_strobe && (rows == '0 || row_height == '0)) |=> !text_en);
endmodule

// File: rtl/vborder_gen.sv
module vborder_gen
    import vb_pkg::*;
#(
    parameter int LINE_W     = 10,
    parameter int ROW_CNT_W  = 8,
    parameter int ROW_H_W    = 4,
    parameter int RESET_ROWS = 25
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 line_strobe,
    input  logic [LINE_W-1:0]    raster_line,
    input  logic [LINE_W-1:0]    border_on_line,
    input  logic [LINE_W-1:0]    border_off_line,
    input  logic [LINE_W-1:0]    text_first_line,
    input  logic [ROW_H_W-1:0]   row_height,
    input  logic                 rows_we,
    input  logic [ROW_CNT_W-1:0] rows_wdata,
    output logic                 border_active,
    output logic                 text_row_enable
);
    logic [ROW_CNT_W-1:0] rows;
    vb_state_e            border_next;

    vb_rowcount_reg #(
        .ROW_CNT_W  (ROW_CNT_W),
        .RESET_ROWS (RESET_ROWS)
    ) u_rows (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (rows_we),
        .wdata (rows_wdata),
        .rows  (rows)
    );

    vb_border_fsm #(
        .LINE_W (LINE_W)
    ) u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .line_strobe   (line_strobe),
        .raster_line   (raster_line),
        .on_line       (border_on_line),
        .off_line      (border_off_line),
        .state_next    (border_next),
        .border_active (border_active)
    );

    vb_text_window #(
        .LINE_W    (LINE_W),
        .ROW_CNT_W (ROW_CNT_W),
        .ROW_H_W   (ROW_H_W)
    ) u_text (
        .clk         (clk),
        .rst_n       (rst_n),
        .line_strobe (line_strobe),
        .raster_line (raster_line),
        .first_line  (text_first_line),
        .row_height  (row_height),
        .rows        (rows),
        .border_next (border_next),
        .text_en     (text_row_enable)
    );

    // R6: border masks text
    p_text_masked_r6: assert property (@(posedge clk) disable iff (!rst_n)
        border_active |-> !text_row_enable);
    // R8: outputs hold between strobes
    p_hold_mid_line_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !line_strobe |=> ($stable(border_active) && $stable(text_row_enable)));
endmodule

// File: tb/test_vborder_gen.sv
module test_vborder_gen;
    localparam int LW = 6;
    localparam int CW = 5;
    localparam int HW = 3;
    localparam int NLINES = 1 << LW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          line_strobe = 1'b0;
    logic [LW-1:0] raster_line = '0;
    logic [LW-1:0] border_on_line = '0;
    logic [LW-1:0] border_off_line = '0;
    logic [LW-1:0] text_first_line = '0;
    logic [HW-1:0] row_height = '0;
    logic          rows_we = 1'b0;
    logic [CW-1:0] rows_wdata = '0;
    logic          border_active;
    logic          text_row_enable;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // bench model
    bit exp_b = 1;
    bit exp_t = 0;
    int exp_rows = 25;

    always #10 clk = ~clk;

    vborder_gen #(.LINE_W(LW), .ROW_CNT_W(CW), .ROW_H_W(HW)) i_vborder_gen (
        .clk(clk), .rst_n(rst_n), .line_strobe(line_strobe), .raster_line(raster_line),
        .border_on_line(border_on_line), .border_off_line(border_off_line),
        .text_first_line(text_first_line), .row_height(row_height),
        .rows_we(rows_we), .rows_wdata(rows_wdata),
        .border_active(border_active), .text_row_enable(text_row_enable));

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s at raster %0d: actual %0d expected %0d", tag, raster_line, act, exp);
        end
    endtask

    task automatic wr_rows(input int v);
        rows_we = 1'b1;
        rows_wdata = CW'(v);
        @(negedge clk);
        rows_we = 1'b0;
        exp_rows = v;
    endtask

    task automatic do_line(input int r);
        bit prev_b;
        string bt;
        string tt;
        int off;
        raster_line = LW'(r);
        line_strobe = 1'b1;
        prev_b = exp_b;
        if (exp_b && r == int'(border_off_line)) exp_b = 0;
        else if (!exp_b && r == int'(border_on_line)) exp_b = 1;
        off = r - int'(text_first_line);
        exp_t = !exp_b && off >= 0 && off < exp_rows * int'(row_height);
        @(negedge clk);
        line_strobe = 1'b0;
        if (prev_b && !exp_b) bt = "R3";
        else if (!prev_b && exp_b) bt = "R1";
        else if (!prev_b) bt = "R2";
        else bt = "R3";
        if (exp_b) tt = "R6";
        else if (exp_rows == 0 || row_height == 0) tt = "R7";
        else tt = "R5";
        chk(bt, border_active, exp_b);
        chk(tt, text_row_enable, exp_t);
        @(negedge clk);
        chk("R8", text_row_enable, exp_t);
        chk("R8", border_active, exp_b);
    endtask

    initial begin : watchdog
        #(20 * 150000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin : main
        int lims[4] = '{25, 0, 3, 31};
        int hts[4]  = '{0, 1, 3, 7};
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R4: reset state
        chk("R4", border_active, 1);
        chk("R4", text_row_enable, 0);

        // R4: default 25 rows of height 2 from line 4 -> text ends after line 53
        row_height = 3'd2;
        text_first_line = 6'd4;
        border_on_line = 6'd62;
        border_off_line = 6'd1;
        for (int r = 0; r < NLINES; r++) begin
            do_line(r);
            if (r == 53) chk("R4", text_row_enable, 1);
            if (r == 54) chk("R4", text_row_enable, 0);
        end

        // sweep of row counts and heights
        foreach (lims[i]) begin
            foreach (hts[j]) begin
                wr_rows(lims[i]);
                row_height = HW'(hts[j]);
                text_first_line = LW'((lims[i] * 3 + hts[j]) % 20);
                border_on_line = LW'(50 + hts[j]);
                border_off_line = LW'(2 + lims[i] % 4);
                for (int r = 0; r < NLINES; r++) do_line(r);
            end
        end

        // R2: border-on moved behind the raster: one frame without border
        wr_rows(25);
        row_height = 3'd1;
        text_first_line = 6'd0;
        border_on_line = 6'd50;
        border_off_line = 6'd5;
        for (int r = 0; r <= 40; r++) do_line(r);
        border_on_line = 6'd30;
        for (int r = 41; r < NLINES; r++) begin
            do_line(r);
            chk("R2", border_active, 0);
        end
        for (int r = 0; r < 32; r++) do_line(r);
        chk("R1", border_active, 1);

        // R8 + R9: a mid-line write does not act until the next strobe
        border_on_line = 6'd60;
        border_off_line = 6'd10;
        row_height = 3'd1;
        text_first_line = 6'd0;
        for (int r = 32; r < NLINES; r++) do_line(r);
        for (int r = 0; r <= 12; r++) do_line(r);
        chk("R9", text_row_enable, 1);
        wr_rows(13);
        @(negedge clk);
        chk("R8", text_row_enable, 1);
        do_line(13);
        chk("R9", text_row_enable, 0);
        wr_rows(14);
        do_line(13);
        chk("R9", text_row_enable, 1);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule